// File: doc/BRIEF.md
# PCI Type-0 Configuration Register File

This block holds the configuration header of a single-function PCI device that fronts a serial-bus host controller. A decoder elsewhere turns configuration cycles into simple requests on a register port. Each request carries a dword offset, four byte enables, write data and a read/write flag. Reads return one cycle later on a registered data output that has a valid strobe.

The header holds several kinds of register. The identity words (vendor, device, class and revision) and the capabilities pointer are constants. The command register has a fixed set of writable enable bits. The status register has hardwired capability bits and sticky error flags, which the bus engine sets through event inputs and software clears by writing ones. The cache line size and the latency timer are plain byte registers. There are two memory base address registers that claim a 2 KB window. The command enables, the two window bases, the cache line size and the latency timer are exported to the bus engine as registered outputs.

Top module: `pcicfg_space`

## Requirements
- R1: After reset a read of dword 0 (offset 00h) returns 8020104Ch, with the device ID in the upper half and the vendor ID in the lower half. A read of dword 2 (offset 08h) returns 0C001000h. A read of dword 3 (offset 0Ch) returns 0 in bits 31:16, which are header type and BIST. A read of dword 13 (offset 34h) returns 00000044h. Writes to these constant fields have no effect.
- R2: The command register sits in bits 15:0 of dword 1. Only bit 8 (system error enable), bit 6 (parity error response), bit 4 (write-and-invalidate enable), bit 2 (bus master enable) and bit 1 (memory space enable) can be written. Every other command bit reads 0. The outputs en_serr, en_parity_resp, en_mwi, en_bus_master and en_mem_space show those five bits. All five reset to 0.
- R3: The status register sits in bits 31:16 of dword 1. Status bits 10:9 always read 01b, bit 4 always reads 1, and bits 7, 6, 5 and all other status bits without a sticky flag read 0. The reset value of the status register is 0210h.
- R4: A pulse on an event input sets its status bit in the cycle after the pulse. The mapping is: ev_addr_par sets bit 15, ev_sys_err sets bit 14, ev_master_abort sets bit 13, ev_target_abort_rcvd sets bit 12, ev_target_abort_sent sets bit 11 and ev_data_par sets bit 8. Bit 14 is set only while the system error enable is 1, and bit 8 is set only while the parity error response bit is 1.
- R5: A sticky status bit clears only on a write to dword 1 that has a 1 in its data position and its byte lane enabled. Writing 0, or writing with the lane disabled, leaves the bit unchanged.
- R6: When an event sets a status bit in the same cycle that software clears it, the bit ends up set.
- R7: In the base address registers at dword 4 (offset 10h) and dword 5 (offset 14h), only bits 31:11 can be written. Bits 10:0 read 0, so writing FFFFFFFFh reads back FFFFF800h. The two registers are independent of each other. Both reset to 0 and are shown on win0_base and win1_base.
- R8: In dword 3, bits 7:0 hold a writable cache line size and bits 15:8 hold a writable latency timer. Both reset to 0 and are shown on cache_line_size and latency_timer.
- R9: In every writable register, a byte lane changes only when its bit of req_be is 1. Bit n of req_be covers data bits 8n+7:8n.
- R10: Reads of every dword offset not named in R1 to R8 return 0, and writes to those offsets change nothing in the block.
- R11: A read request is answered in the next cycle: rd_valid is 1 and rd_data holds the register contents as they stood before the request's clock edge. rd_valid is 0 in any cycle that follows a non-read cycle. During reset rd_valid and rd_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Dword offset into configuration space |
| req_be | input | 4 | Byte lane enables for writes |
| req_wdata | input | 32 | Write data |
| ev_addr_par | input | 1 | Event: parity error detected |
| ev_sys_err | input | 1 | Event: system error signalled |
| ev_master_abort | input | 1 | Event: own cycle ended by master abort |
| ev_target_abort_rcvd | input | 1 | Event: own cycle ended by target abort |
| ev_target_abort_sent | input | 1 | Event: target abort signalled by this device |
| ev_data_par | input | 1 | Event: data parity error while bus master |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| en_mem_space | output | 1 | Memory space response enable |
| en_bus_master | output | 1 | Bus master enable |
| en_mwi | output | 1 | Write-and-invalidate enable |
| en_parity_resp | output | 1 | Parity error response enable |
| en_serr | output | 1 | System error driver enable |
| win0_base | output | 32 | First window base, low 11 bits zero |
| win1_base | output | 32 | Second window base, low 11 bits zero |
| cache_line_size | output | 8 | Cache line size |
| latency_timer | output | 8 | Latency timer |

## Verification
A flop that holds a wrong value in the command, cache line or base registers shows on its exported output in the same cycle. It also shows on rd_data one cycle after the next read of that dword. A sticky status flag that sets or clears wrongly can only be seen by reading dword 1, so the bench reads that dword right after every event pulse and every clear write. This includes a set and a clear landing in the same cycle, and events that arrive while their enable gates are closed. Decode faults, where a write lands on the wrong offset or a byte lane ignores its enable, show up as mismatches on later reads. These include writes leaking into constant or unimplemented offsets, so the randomized traffic covers all offsets and all byte-enable patterns.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam int unsigned CFG_DW    = 32;
  localparam int unsigned CFG_LANES = CFG_DW / 8;

  // dword offsets inside the header
  localparam int unsigned OFS_IDENT  = 0;
  localparam int unsigned OFS_CMDSTA = 1;
  localparam int unsigned OFS_CLASS  = 2;
  localparam int unsigned OFS_MISC   = 3;
  localparam int unsigned OFS_WIN0   = 4;
  localparam int unsigned OFS_WIN1   = 5;
  localparam int unsigned OFS_CAPPTR = 13;

  // command bit positions
  localparam int unsigned CMD_MEM    = 1;
  localparam int unsigned CMD_MASTER = 2;
  localparam int unsigned CMD_MWI    = 4;
  localparam int unsigned CMD_PERR   = 6;
  localparam int unsigned CMD_SERR   = 8;

  // status bit positions
  localparam int unsigned STA_DPAR   = 8;
  localparam int unsigned STA_TABT_S = 11;
  localparam int unsigned STA_TABT_R = 12;
  localparam int unsigned STA_MABT   = 13;
  localparam int unsigned STA_SYSERR = 14;
  localparam int unsigned STA_PARERR = 15;

  localparam logic [15:0] CMD_WMASK = 16'h0156;
  localparam logic [15:0] STA_W1C   = 16'hF900;
  localparam logic [15:0] STA_FIXED = 16'h0210;

  typedef struct packed {
    logic par_err;
    logic sys_err;
    logic mabort;
    logic tabort_rcvd;
    logic tabort_sent;
    logic data_par;
  } cfg_event_t;

endpackage

// File: rtl/pcicfg_masked_reg.sv
module pcicfg_masked_reg #(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] WMASK  = '1,
  parameter logic [W-1:0] RSTVAL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (WMASK[i]) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst)                 q[i] <= RSTVAL[i];
        else if (we && be[i/8])  q[i] <= wdata[i];
      end
    end else begin : g_ro
      assign q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/pcicfg_status_reg.sv
module pcicfg_status_reg #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] W1C_MASK = 16'hF900,
  parameter logic [W-1:0] FIXED    = 16'h0210
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   set_vec,
  input  logic           clr_we,
  input  logic [W/8-1:0] clr_be,
  input  logic [W-1:0]   clr_data,
  output logic [W-1:0]   q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (W1C_MASK[i]) begin : g_sticky
      logic clr_hit;
      assign clr_hit = clr_we && clr_be[i/8] && clr_data[i];
      always_ff @(posedge clk) begin
        if (rst) q[i] <= 1'b0;
        else     q[i] <= set_vec[i] || (q[i] && !clr_hit);
      end
    end else begin : g_fixed
      assign q[i] = FIXED[i];
    end
  end

endmodule

// File: rtl/pcicfg_rd_port.sv
module pcicfg_rd_port
  import pcicfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       w_ident,
  input  logic [31:0]       w_cmdsta,
  input  logic [31:0]       w_class,
  input  logic [31:0]       w_misc,
  input  logic [31:0]       w_win0,
  input  logic [31:0]       w_win1,
  input  logic [31:0]       w_capptr,
  output logic              rd_valid,
  output logic [31:0]       rd_data
);

  logic [31:0] sel;

  always_comb begin
    case (addr)
      ADDR_W'(OFS_IDENT):  sel = w_ident;
      ADDR_W'(OFS_CMDSTA): sel = w_cmdsta;
      ADDR_W'(OFS_CLASS):  sel = w_class;
      ADDR_W'(OFS_MISC):   sel = w_misc;
      ADDR_W'(OFS_WIN0):   sel = w_win0;
      ADDR_W'(OFS_WIN1):   sel = w_win1;
      ADDR_W'(OFS_CAPPTR): sel = w_capptr;
      default:             sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

endmodule

// File: rtl/pcicfg_space.sv
module pcicfg_space
  import pcicfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned WIN_LOG2  = 11,
  parameter logic [15:0] VENDOR_ID = 16'h104C,
  parameter logic [15:0] DEVICE_ID = 16'h8020,
  parameter logic [31:0] CLASS_REV = 32'h0C00_1000,
  parameter logic [7:0]  CAP_PTR   = 8'h44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  input  logic              ev_addr_par,
  input  logic              ev_sys_err,
  input  logic              ev_master_abort,
  input  logic              ev_target_abort_rcvd,
  input  logic              ev_target_abort_sent,
  input  logic              ev_data_par,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              en_mem_space,
  output logic              en_bus_master,
  output logic              en_mwi,
  output logic              en_parity_resp,
  output logic              en_serr,
  output logic [31:0]       win0_base,
  output logic [31:0]       win1_base,
  output logic [7:0]        cache_line_size,
  output logic [7:0]        latency_timer
);

  localparam logic [31:0] WIN_WMASK = ~((32'd1 << WIN_LOG2) - 32'd1);

  logic wr_en, rd_en;
  logic hit_cmdsta, hit_misc, hit_win0, hit_win1;
  logic [15:0] cmd_q, sta_q, misc_q, sta_set;
  cfg_event_t ev;

  assign wr_en = req_valid && req_write;
  assign rd_en = req_valid && !req_write;

  assign hit_cmdsta = (req_addr == ADDR_W'(OFS_CMDSTA));
  assign hit_misc   = (req_addr == ADDR_W'(OFS_MISC));
  assign hit_win0   = (req_addr == ADDR_W'(OFS_WIN0));
  assign hit_win1   = (req_addr == ADDR_W'(OFS_WIN1));

  assign ev = '{par_err: ev_addr_par, sys_err: ev_sys_err, mabort: ev_master_abort,
                tabort_rcvd: ev_target_abort_rcvd, tabort_sent: ev_target_abort_sent,
                data_par: ev_data_par};

  always_comb begin
    sta_set             = '0;
    sta_set[STA_PARERR] = ev.par_err;
    sta_set[STA_SYSERR] = ev.sys_err && cmd_q[CMD_SERR];
    sta_set[STA_MABT]   = ev.mabort;
    sta_set[STA_TABT_R] = ev.tabort_rcvd;
    sta_set[STA_TABT_S] = ev.tabort_sent;
    sta_set[STA_DPAR]   = ev.data_par && cmd_q[CMD_PERR];
  end

  pcicfg_masked_reg #(.W(16), .WMASK(CMD_WMASK), .RSTVAL(16'h0000)) u_cmd (
    .clk(clk), .rst(rst), .we(wr_en && hit_cmdsta), .be(req_be[1:0]),
    .wdata(req_wdata[15:0]), .q(cmd_q)
  );

  pcicfg_status_reg #(.W(16), .W1C_MASK(STA_W1C), .FIXED(STA_FIXED)) u_sta (
    .clk(clk), .rst(rst), .set_vec(sta_set), .clr_we(wr_en && hit_cmdsta),
    .clr_be(req_be[3:2]), .clr_data(req_wdata[31:16]), .q(sta_q)
  );

  pcicfg_masked_reg #(.W(16), .WMASK(16'hFFFF), .RSTVAL(16'h0000)) u_misc (
    .clk(clk), .rst(rst), .we(wr_en && hit_misc), .be(req_be[1:0]),
    .wdata(req_wdata[15:0]), .q(misc_q)
  );

  pcicfg_masked_reg #(.W(32), .WMASK(WIN_WMASK), .RSTVAL(32'h0)) u_win0 (
    .clk(clk), .rst(rst), .we(wr_en && hit_win0), .be(req_be),
    .wdata(req_wdata), .q(win0_base)
  );

  pcicfg_masked_reg #(.W(32), .WMASK(WIN_WMASK), .RSTVAL(32'h0)) u_win1 (
    .clk(clk), .rst(rst), .we(wr_en && hit_win1), .be(req_be),
    .wdata(req_wdata), .q(win1_base)
  );

  pcicfg_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(req_addr),
    .w_ident({DEVICE_ID, VENDOR_ID}),
    .w_cmdsta({sta_q, cmd_q}),
    .w_class(CLASS_REV),
    .w_misc({16'h0000, misc_q}),
    .w_win0(win0_base),
    .w_win1(win1_base),
    .w_capptr({24'h0, CAP_PTR}),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign en_mem_space    = cmd_q[CMD_MEM];
  assign en_bus_master   = cmd_q[CMD_MASTER];
  assign en_mwi          = cmd_q[CMD_MWI];
  assign en_parity_resp  = cmd_q[CMD_PERR];
  assign en_serr         = cmd_q[CMD_SERR];
  assign cache_line_size = misc_q[7:0];
  assign latency_timer   = misc_q[15:8];

endmodule

// File: rtl/pcicfg_space_chk.sv
module pcicfg_space_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_be,
  input logic [31:0]       req_wdata,
  input logic              ev_addr_par,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [15:0]       sta_q
);

  logic rd_req, clr_par;
  assign rd_req  = req_valid && !req_write;
  assign clr_par = req_valid && req_write && (req_addr == ADDR_W'(1)) && req_be[3] && req_wdata[31];

  AST_IDENT_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_addr == ADDR_W'(0)) |=> (rd_data == 32'h8020_104C)); // R1

  AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_addr == ADDR_W'(1)) |=> ((rd_data & 32'h0000_FEA9) == 32'h0)); // R2

  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_addr == ADDR_W'(1)) |=>
      (rd_data[26:25] == 2'b01 && rd_data[20] && rd_data[23:21] == 3'b000)); // R3

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_addr_par |=> sta_q[15]); // R4

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sta_q[15] && !clr_par) |=> sta_q[15]); // R5

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (clr_par && !ev_addr_par) |=> !sta_q[15]); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (clr_par && ev_addr_par) |=> sta_q[15]); // R6

  AST_WIN_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (req_addr == ADDR_W'(4) || req_addr == ADDR_W'(5))) |=> (rd_data[10:0] == 11'h0)); // R7

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_req && req_addr > ADDR_W'(5) && req_addr != ADDR_W'(13)) |=> (rd_data == 32'h0)); // R10

  AST_RD_STROBE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid); // R11

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rd_valid); // R11

endmodule

bind pcicfg_space pcicfg_space_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
  .ev_addr_par(ev_addr_par), .rd_valid(rd_valid), .rd_data(rd_data),
  .sta_q(sta_q)
);

// File: tb/pcicfg_space_test.sv
module pcicfg_space_test;

  localparam int unsigned AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [5:0]  ev = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic en_mem_space, en_bus_master, en_mwi, en_parity_resp, en_serr;
  logic [31:0] win0_base, win1_base;
  logic [7:0]  cache_line_size, latency_timer;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model
  logic [15:0] m_cmd = '0, m_sta = '0, m_misc = '0;
  logic [31:0] m_w0 = '0, m_w1 = '0;

  always #5 clk = ~clk;

  pcicfg_space #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .ev_addr_par(ev[5]), .ev_sys_err(ev[4]), .ev_master_abort(ev[3]),
    .ev_target_abort_rcvd(ev[2]), .ev_target_abort_sent(ev[1]), .ev_data_par(ev[0]),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .en_mem_space(en_mem_space), .en_bus_master(en_bus_master), .en_mwi(en_mwi),
    .en_parity_resp(en_parity_resp), .en_serr(en_serr),
    .win0_base(win0_base), .win1_base(win1_base),
    .cache_line_size(cache_line_size), .latency_timer(latency_timer)
  );

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be, input logic [31:0] mask);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = (mask[i] && be[i/8]) ? nw[i] : old[i];
    return r & mask;
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    case (a)
      6'd0:  return 32'h8020_104C;
      6'd1:  return {m_sta | 16'h0210, m_cmd};
      6'd2:  return 32'h0C00_1000;
      6'd3:  return {16'h0, m_misc};
      6'd4:  return m_w0;
      6'd5:  return m_w1;
      6'd13: return 32'h0000_0044;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " enables"}, {27'h0, en_serr, en_parity_resp, en_mwi, en_bus_master, en_mem_space},
        {27'h0, m_cmd[8], m_cmd[6], m_cmd[4], m_cmd[2], m_cmd[1]});
    chk({tag, " win0"}, win0_base, m_w0);
    chk({tag, " win1"}, win1_base, m_w1);
    chk({tag, " misc"}, {16'h0, latency_timer, cache_line_size}, {16'h0, m_misc});
  endtask

  // one request cycle, optional events, then check and model update
  task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                      input logic [3:0] be, input logic [31:0] d, input logic [5:0] e,
                      input string tag);
    logic [31:0] expv;
    logic [15:0] setv, clrv;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = a; req_be = be; req_wdata = d; ev = e;
    expv = exp_read(a);
    setv = {e[5], e[4] & m_cmd[8], e[3], e[2], e[1], 2'b00, e[0] & m_cmd[6], 8'h00};
    clrv = '0;
    if (v && w && a == 6'd1) begin
      clrv[15:8] = be[3] ? d[31:24] : 8'h00;
      clrv[7:0]  = be[2] ? d[23:16] : 8'h00;
    end
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; ev = '0;
    m_sta = ((m_sta & ~clrv) | setv) & 16'hF900;
    if (v && w) begin
      case (a)
        6'd1: m_cmd  = merge({16'h0, m_cmd}, d, {2'b00, be[1:0]}, 32'h0000_0156)[15:0];
        6'd3: m_misc = merge({16'h0, m_misc}, d, {2'b00, be[1:0]}, 32'h0000_FFFF)[15:0];
        6'd4: m_w0   = merge(m_w0, d, be, 32'hFFFF_F800);
        6'd5: m_w1   = merge(m_w1, d, be, 32'hFFFF_F800);
        default: ;
      endcase
    end
    chk({tag, " rd_valid"}, {31'h0, rd_valid}, {31'h0, v && !w});
    if (v && !w) chk(tag, rd_data, expv);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b0, a, 4'h0, 32'h0, 6'h0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] d,
                    input string tag);
    step(1'b1, 1'b1, a, be, d, 6'h0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R11 reset rd_valid", {31'h0, rd_valid}, 32'h0);
    chk("R11 reset rd_data", rd_data, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk_outs("R2 R8 reset outputs");

    // R1 identity and constant words
    rd(6'd0,  "R1 ident");
    rd(6'd2,  "R1 class");
    rd(6'd3,  "R1 misc upper zero");
    rd(6'd13, "R1 cap ptr");
    rd(6'd1,  "R3 status reset 0210");
    wr(6'd0, 4'hF, 32'hFFFF_FFFF, "R1 write ident");
    wr(6'd2, 4'hF, 32'hFFFF_FFFF, "R1 write class");
    wr(6'd13, 4'hF, 32'hFFFF_FFFF, "R1 write cap");
    wr(6'd3, 4'hC, 32'hFFFF_FFFF, "R1 write header bist");
    rd(6'd0,  "R1 ident after write");
    rd(6'd2,  "R1 class after write");
    rd(6'd13, "R1 cap after write");
    rd(6'd3,  "R1 misc unchanged");

    // R2 command writable bits
    wr(6'd1, 4'h3, 32'h0000_FFFF, "R2 cmd all ones");
    rd(6'd1, "R2 cmd reads 0156");
    chk_outs("R2 enables on");

    // R7 windows
    wr(6'd4, 4'hF, 32'hFFFF_FFFF, "R7 win0 ones");
    rd(6'd4, "R7 win0 FFFFF800");
    rd(6'd5, "R7 win1 untouched");
    wr(6'd5, 4'hF, 32'h1234_5678, "R7 win1 write");
    rd(6'd5, "R7 win1 readback");
    chk_outs("R7 window outputs");

    // R8 R9 byte lanes
    wr(6'd3, 4'h1, 32'hAABB_CCDD, "R9 cache lane only");
    rd(6'd3, "R8 cache DD");
    wr(6'd3, 4'h2, 32'h0000_5A00, "R9 latency lane only");
    rd(6'd3, "R8 latency 5A");
    wr(6'd4, 4'h4, 32'h0000_0000, "R9 win0 lane2");
    rd(6'd4, "R9 win0 lane2 cleared");
    chk_outs("R8 R9 outputs");

    // R4 events with enables open
    step(1'b0, 1'b0, 6'd0, 4'h0, 32'h0, 6'h3F, "R4 all events");
    rd(6'd1, "R4 status all set");
    // R5 zero writes and disabled lanes keep flags
    wr(6'd1, 4'hC, 32'h0000_0156, "R5 write zeros");
    rd(6'd1, "R5 flags kept on zero write");
    wr(6'd1, 4'h3, 32'hFFFF_0156, "R5 lane disabled");
    rd(6'd1, "R5 flags kept lane off");
    wr(6'd1, 4'h8, 32'h8000_0000, "R5 clear bit15");
    rd(6'd1, "R5 bit15 cleared only");
    // R6 set wins
    step(1'b1, 1'b1, 6'd1, 4'h8, 32'h8000_0000, 6'h20, "R6 set and clear");
    rd(6'd1, "R6 set wins");
    wr(6'd1, 4'hF, 32'hFFFF_0000, "R5 clear all");
    rd(6'd1, "R5 all cleared, cmd zero");
    // R4 gating with enables closed
    step(1'b0, 1'b0, 6'd0, 4'h0, 32'h0, 6'h11, "R4 gated events");
    rd(6'd1, "R4 gated bits stay clear");

    // R10 unimplemented offset
    wr(6'd20, 4'hF, 32'hFFFF_FFFF, "R10 write unimpl");
    rd(6'd20, "R10 unimpl reads 0");
    rd(6'd4,  "R10 win0 unchanged");
    rd(6'd63, "R10 top offset reads 0");

    // random traffic
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      a = (k < 3'd6) ? AW'($urandom_range(0, 6)) : AW'($urandom_range(0, 63));
      case ($urandom_range(0, 3))
        0: step(1'b1, 1'b1, a, 4'($urandom), $urandom, 6'($urandom & (($urandom_range(0,3)==0) ? 32'h3F : 32'h0)), "R9 R10 random write");
        1, 2: rd(a, "R11 random read");
        default: step(1'b0, 1'b0, a, 4'h0, 32'h0, 6'($urandom), "R4 random events");
      endcase
      if (n % 50 == 0) chk_outs("R2 R8 random outputs");
    end
    rd(6'd1, "R5 final status");
    summary();
  end

endmodule